// File: doc/BRIEF.md
# Variable Bit-Field Extract and Compare Unit

This unit is one execution slice of a processor datapath. Each accepted request names a field inside a 64-bit data window by its lowest bit position and its width in bits. The unit then does one of two things. In extract mode it returns that field as a 32-bit value, filled on the left either with copies of the field's top bit or with zeros. In compare mode it widens the field the same way, compares it against a 32-bit source operand, and reports the outcome only through the condition flags.

Every request produces its answer one clock later. The caller supplies the carry flag currently in force, so that extract operations can pass it through unchanged. A field that does not fit, meaning it is wider than 32 bits or reaches past bit 63 of the window, raises a fault flag. When that happens, the result and flags from earlier operations are left as they were.

Top module: `bitfield_unit`

## Requirements
- R1: The opcode selects the operation: 0xEE extracts with sign fill, 0xEF extracts with zero fill, 0xEC compares against the sign-filled field and 0xED compares against the zero-filled field. An in_valid carrying any other opcode is not accepted and produces no out_valid.
- R2: out_valid is high in exactly the cycle after an accepted request. A synchronous active-high rst clears out_valid, fault, result and all four flags to 0.
- R3: An extract returns window bits pos through pos+size-1, with bit pos as bit 0 of result. Bits from size upward are copies of the field's top bit for 0xEE and zeros for 0xEF.
- R4: After an extract, cc_n equals result bit 31 and cc_z is high when result is zero. cc_v is 0, and cc_c equals the c_in of the request.
- R5: An extract with size 0 returns 0, which gives cc_z=1 and cc_n=0.
- R6: After a compare, cc_n means field < src as signed values, cc_z means field == src, and cc_c means field < src as unsigned values. cc_v is 0.
- R7: A compare leaves result holding its previous value.
- R8: A compare with size 0 uses the value 0 as the field.
- R9: fault is high together with out_valid when size > 32 or pos+size > 64. fault is never high without out_valid.
- R10: On a faulting request, result and all four flags keep their previous values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Request strobe |
| opcode | input | 8 | Operation select |
| pos | input | 6 | Lowest bit of the field in the window |
| size | input | 8 | Field width in bits |
| data_win | input | 64 | Data window holding the field |
| src | input | 32 | Compare operand |
| c_in | input | 1 | Carry flag currently in force |
| out_valid | output | 1 | Result strobe |
| result | output | 32 | Extracted value |
| fault | output | 1 | Request had an illegal position or size |
| cc_n | output | 1 | Negative flag |
| cc_z | output | 1 | Zero flag |
| cc_v | output | 1 | Overflow flag |
| cc_c | output | 1 | Carry flag |

## Verification
The properties assume that in_valid, opcode, pos, size and c_in are driven to known values in every cycle once reset is released. They also assume that no request arrives while rst is high, because the checks look one cycle back at the request that produced each result. The stimulus changes inputs only on falling edges and holds in_valid low through reset. It covers every opcode, including ones that must be rejected, and sizes up to 36 so that the illegal-size and overflowing-position cases occur along with legal ones. Back-to-back requests exercise the one-cycle pipeline.

// File: rtl/bf_pkg.sv
package bf_pkg;
   localparam logic [7:0] OP_CMP_SX = 8'hEC;
   localparam logic [7:0] OP_CMP_ZX = 8'hED;
   localparam logic [7:0] OP_EXT_SX = 8'hEE;
   localparam logic [7:0] OP_EXT_ZX = 8'hEF;

   typedef struct packed {
      logic n;
      logic z;
      logic v;
      logic c;
   } flags_t;

   // all four field opcodes share bits 7:2
   function automatic logic is_field_op(input logic [7:0] op);
      return op[7:2] == OP_CMP_SX[7:2];
   endfunction
endpackage

// File: rtl/bf_extract.sv
module bf_extract #(
   parameter int WIN_W      = 64,
   parameter int RES_W      = 32,
   parameter int SIZE_W     = 8,
   parameter bit LOG_SHIFT  = 1'b1,
   localparam int POS_W     = $clog2(WIN_W),
   localparam int IDX_W     = $clog2(RES_W)
) (
   input  logic [WIN_W-1:0]  win,
   input  logic [POS_W-1:0]  pos,
   input  logic [SIZE_W-1:0] size,
   input  logic              sign_fill,
   output logic [RES_W-1:0]  value
);
   logic [WIN_W-1:0] shifted;

   generate
      if (LOG_SHIFT) begin : g_log
         logic [WIN_W-1:0] stage [POS_W+1];
         assign stage[0] = win;
         for (genvar k = 0; k < POS_W; k++) begin : g_stage
            assign stage[k+1] = pos[k] ? (stage[k] >> (2 ** k)) : stage[k];
         end
         assign shifted = stage[POS_W];
      end else begin : g_flat
         assign shifted = win >> pos;
      end
   endgenerate

   logic [RES_W:0]   mask_w;
   logic [RES_W-1:0] mask;
   logic [RES_W-1:0] field;
   logic [IDX_W-1:0] top_idx;
   logic             top_bit;

   always_comb begin
      mask_w  = ({{RES_W{1'b0}}, 1'b1} << size) - 1'b1;
      mask    = mask_w[RES_W-1:0];
      field   = shifted[RES_W-1:0] & mask;
      top_idx = IDX_W'(size - 1'b1);
      top_bit = (size != '0) && field[top_idx];
      value   = (sign_fill && top_bit) ? (field | ~mask) : field;
   end
endmodule

// File: rtl/bf_compare.sv
module bf_compare #(
   parameter int RES_W = 32
) (
   input  logic [RES_W-1:0] field,
   input  logic [RES_W-1:0] src,
   output logic             lt_s,
   output logic             eq,
   output logic             lt_u
);
   always_comb begin
      lt_s = $signed(field) < $signed(src);
      eq   = field == src;
      lt_u = field < src;
   end
endmodule

// File: rtl/bf_range.sv
module bf_range #(
   parameter int WIN_W  = 64,
   parameter int RES_W  = 32,
   parameter int SIZE_W = 8,
   localparam int POS_W = $clog2(WIN_W),
   localparam int SUM_W = ((POS_W > SIZE_W) ? POS_W : SIZE_W) + 1
) (
   input  logic [POS_W-1:0]  pos,
   input  logic [SIZE_W-1:0] size,
   output logic              bad
);
   logic [SUM_W-1:0] reach;
   always_comb begin
      reach = SUM_W'(pos) + SUM_W'(size);
      bad   = (SUM_W'(size) > SUM_W'(RES_W)) || (reach > SUM_W'(WIN_W));
   end
endmodule

// File: rtl/bitfield_unit.sv
module bitfield_unit #(
   parameter int WIN_W     = 64,
   parameter int RES_W     = 32,
   parameter int SIZE_W    = 8,
   parameter bit LOG_SHIFT = 1'b1,
   localparam int POS_W    = $clog2(WIN_W)
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              in_valid,
   input  logic [7:0]        opcode,
   input  logic [POS_W-1:0]  pos,
   input  logic [SIZE_W-1:0] size,
   input  logic [WIN_W-1:0]  data_win,
   input  logic [RES_W-1:0]  src,
   input  logic              c_in,
   output logic              out_valid,
   output logic [RES_W-1:0]  result,
   output logic              fault,
   output logic              cc_n,
   output logic              cc_z,
   output logic              cc_v,
   output logic              cc_c
);
   import bf_pkg::*;

   generate
      if (RES_W > WIN_W) begin : g_bad_res
         $error("RES_W must not exceed WIN_W");
      end
      if ((1 << SIZE_W) <= RES_W) begin : g_bad_size
         $error("SIZE_W too narrow to express RES_W");
      end
      if ((1 << POS_W) != WIN_W) begin : g_bad_win
         $error("WIN_W must be a power of two");
      end
   endgenerate

   logic             accept, is_cmp, sign_fill, bad;
   logic [RES_W-1:0] value;
   logic             lt_s, eq, lt_u;
   flags_t           flags_q;

   assign accept    = in_valid && is_field_op(opcode);
   assign is_cmp    = ~opcode[1];
   assign sign_fill = ~opcode[0];

   bf_extract #(
      .WIN_W(WIN_W), .RES_W(RES_W), .SIZE_W(SIZE_W), .LOG_SHIFT(LOG_SHIFT)
   ) u_extract (
      .win(data_win), .pos(pos), .size(size),
      .sign_fill(sign_fill), .value(value)
   );

   bf_compare #(.RES_W(RES_W)) u_compare (
      .field(value), .src(src), .lt_s(lt_s), .eq(eq), .lt_u(lt_u)
   );

   bf_range #(.WIN_W(WIN_W), .RES_W(RES_W), .SIZE_W(SIZE_W)) u_range (
      .pos(pos), .size(size), .bad(bad)
   );

   always_ff @(posedge clk) begin
      if (rst) begin
         out_valid <= 1'b0;
         fault     <= 1'b0;
         result    <= '0;
         flags_q   <= '0;
      end else begin
         out_valid <= accept;
         fault     <= accept && bad;
         if (accept && !bad) begin
            if (is_cmp) begin
               flags_q <= '{n: lt_s, z: eq, v: 1'b0, c: lt_u};
            end else begin
               result  <= value;
               flags_q <= '{n: value[RES_W-1], z: (value == '0), v: 1'b0, c: c_in};
            end
         end
      end
   end

   assign cc_n = flags_q.n;
   assign cc_z = flags_q.z;
   assign cc_v = flags_q.v;
   assign cc_c = flags_q.c;
endmodule

// File: rtl/bitfield_unit_chk.sv
module bitfield_unit_chk #(
   parameter int WIN_W    = 64,
   parameter int RES_W    = 32,
   parameter int SIZE_W   = 8,
   localparam int POS_W   = $clog2(WIN_W)
) (
   input logic              clk,
   input logic              rst,
   input logic              in_valid,
   input logic [7:0]        opcode,
   input logic [POS_W-1:0]  pos,
   input logic [SIZE_W-1:0] size,
   input logic              c_in,
   input logic              out_valid,
   input logic [RES_W-1:0]  result,
   input logic              fault,
   input logic              cc_n,
   input logic              cc_z,
   input logic              cc_v,
   input logic              cc_c
);
   // R2
   valid_follow_chk: assert property (@(posedge clk) disable iff (rst)
      (in_valid && opcode[7:2] == 6'b111011) |=> out_valid);

   // R1
   no_accept_chk: assert property (@(posedge clk) disable iff (rst)
      !(in_valid && opcode[7:2] == 6'b111011) |=> !out_valid);

   // R9
   fault_gated_chk: assert property (@(posedge clk) disable iff (rst)
      fault |-> out_valid);

   // R9
   size_fault_chk: assert property (@(posedge clk) disable iff (rst)
      (out_valid && $past(size) > SIZE_W'(RES_W)) |-> fault);

   // R10
   fault_hold_chk: assert property (@(posedge clk) disable iff (rst)
      (out_valid && fault) |-> ($stable(result) && $stable(cc_n) && $stable(cc_z)
                                && $stable(cc_v) && $stable(cc_c)));

   // R7
   cmp_hold_chk: assert property (@(posedge clk) disable iff (rst)
      (out_valid && !fault && !$past(opcode[1])) |-> $stable(result));

   // R4
   ext_flags_chk: assert property (@(posedge clk) disable iff (rst)
      (out_valid && !fault && $past(opcode[1])) |->
         (cc_c == $past(c_in) && cc_n == result[RES_W-1] && cc_z == (result == '0)));

   // R6
   v_clear_chk: assert property (@(posedge clk) disable iff (rst)
      (out_valid && !fault) |-> !cc_v);

   // R5
   zero_ext_chk: assert property (@(posedge clk) disable iff (rst)
      (out_valid && $past(size) == '0 && $past(opcode[1])) |-> (result == '0 && cc_z));
endmodule

bind bitfield_unit bitfield_unit_chk #(
   .WIN_W(WIN_W), .RES_W(RES_W), .SIZE_W(SIZE_W)
) u_chk (.*);

// File: tb/bitfield_unit_test.sv
module bitfield_unit_test;
   typedef struct {
      logic [31:0] res;
      logic        n, z, v, c, flt;
      string       tag;
   } exp_t;

   logic        clk = 1'b0;
   logic        rst;
   logic        in_valid;
   logic [7:0]  opcode;
   logic [5:0]  pos;
   logic [7:0]  size;
   logic [63:0] data_win;
   logic [31:0] src;
   logic        c_in;
   logic        out_valid, fault, cc_n, cc_z, cc_v, cc_c;
   logic [31:0] result;

   int tests = 0;
   int fails = 0;
   exp_t sb[$];
   logic [31:0] m_res;
   logic m_n, m_z, m_v, m_c;
   bit done = 0;

   always #10 clk = ~clk;

   bitfield_unit uut (
      .clk(clk), .rst(rst), .in_valid(in_valid), .opcode(opcode), .pos(pos),
      .size(size), .data_win(data_win), .src(src), .c_in(c_in),
      .out_valid(out_valid), .result(result), .fault(fault),
      .cc_n(cc_n), .cc_z(cc_z), .cc_v(cc_v), .cc_c(cc_c)
   );

   task automatic finish_run();
      if (!done) begin
         done = 1;
         $display("  [TB] %0d tests run, %0d failed", tests, fails);
         $finish;
      end
   endtask

   // scoreboard monitor
   always @(negedge clk) begin
      if (!rst && out_valid) begin
         tests++;
         if (sb.size() == 0) begin
            fails++;
            $display("FAIL R2: unexpected out_valid, got 1 expected 0");
         end else begin
            exp_t e;
            e = sb.pop_front();
            if (result !== e.res || cc_n !== e.n || cc_z !== e.z || cc_v !== e.v ||
                cc_c !== e.c || fault !== e.flt) begin
               fails++;
               $display("FAIL %s: got res=%h nzvc=%b%b%b%b flt=%b expected res=%h nzvc=%b%b%b%b flt=%b",
                        e.tag, result, cc_n, cc_z, cc_v, cc_c, fault,
                        e.res, e.n, e.z, e.v, e.c, e.flt);
            end
         end
      end
   end

   // watchdog
   initial begin
      repeat (100000) @(posedge clk);
      tests++;
      fails++;
      $display("FAIL watchdog: run hung, got timeout expected completion");
      finish_run();
   end

   task automatic drive(input logic [7:0] op, input int p, input int s,
                        input logic [63:0] w, input logic [31:0] sr,
                        input logic ci, input string tag);
      exp_t e;
      logic [31:0] f;
      bit bad, cmp, sx;
      @(negedge clk);
      in_valid = 1'b1; opcode = op; pos = 6'(p); size = 8'(s);
      data_win = w; src = sr; c_in = ci;
      bad = (s > 32) || (p + s > 64);
      cmp = (op == 8'hEC) || (op == 8'hED);
      sx  = (op == 8'hEC) || (op == 8'hEE);
      f = '0;
      if (!bad) begin
         for (int i = 0; i < s; i++) f[i] = w[p + i];
         if (sx && s > 0 && f[s-1])
            for (int i = s; i < 32; i++) f[i] = 1'b1;
         if (cmp) begin
            m_n = $signed(f) < $signed(sr);
            m_z = (f == sr);
            m_v = 1'b0;
            m_c = (f < sr);
         end else begin
            m_res = f;
            m_n = f[31];
            m_z = (f == 0);
            m_v = 1'b0;
            m_c = ci;
         end
      end
      e.res = m_res; e.n = m_n; e.z = m_z; e.v = m_v; e.c = m_c;
      e.flt = bad; e.tag = tag;
      sb.push_back(e);
   endtask

   task automatic idle();
      @(negedge clk);
      in_valid = 1'b0;
   endtask

   // R1: rejected opcode gives no out_valid next cycle
   task automatic drive_bad(input logic [7:0] op);
      @(negedge clk);
      in_valid = 1'b1; opcode = op; pos = 6'd0; size = 8'd8;
      @(negedge clk);
      in_valid = 1'b0;
      tests++;
      if (out_valid !== 1'b0) begin
         fails++;
         $display("FAIL R1: opcode %h got out_valid=%b expected 0", op, out_valid);
      end
   endtask

   initial begin
      rst = 1'b1; in_valid = 1'b0; opcode = 8'h00; pos = '0; size = '0;
      data_win = '0; src = '0; c_in = 1'b0;
      m_res = '0; m_n = 0; m_z = 0; m_v = 0; m_c = 0;
      repeat (3) @(negedge clk);
      // R2 reset state
      tests++;
      if (out_valid !== 0 || fault !== 0 || result !== 0 || {cc_n, cc_z, cc_v, cc_c} !== 4'b0) begin
         fails++;
         $display("FAIL R2: reset got v=%b f=%b res=%h cc=%b%b%b%b expected all 0",
                  out_valid, fault, result, cc_n, cc_z, cc_v, cc_c);
      end
      rst = 1'b0;

      drive(8'hEF, 0, 8, 64'h0000_0000_0000_00A5, 0, 1'b1, "R3 zext low byte");
      drive(8'hEE, 4, 8, 64'h0000_0000_0000_0F90, 0, 1'b0, "R3 sext negative");
      drive(8'hEE, 32, 32, 64'h8000_0001_1234_5678, 0, 1'b1, "R4 sext full width");
      drive(8'hEF, 31, 32, 64'h0000_0000_8000_0000, 0, 1'b0, "R3 zext pos31 size32");
      drive(8'hEE, 63, 1, 64'h8000_0000_0000_0000, 0, 1'b1, "R3 top bit one-wide");
      drive(8'hEF, 10, 0, 64'hFFFF_FFFF_FFFF_FFFF, 0, 1'b1, "R5 zero size extract");
      drive(8'hEE, 60, 8, 64'hFFFF_FFFF_FFFF_FFFF, 0, 1'b0, "R9 R10 reach past window");
      drive(8'hEF, 0, 33, 64'hFFFF_FFFF_FFFF_FFFF, 0, 1'b0, "R9 R10 size too large");
      drive(8'hED, 8, 16, 64'h0000_0000_00AB_CD00, 32'h0000_ABCD, 1'b0, "R6 R7 compare equal");
      drive(8'hEC, 0, 8, 64'h0000_0000_0000_0080, 32'h0000_0001, 1'b0, "R6 signed less");
      drive(8'hED, 0, 8, 64'h0000_0000_0000_0080, 32'hFFFF_FFFF, 1'b0, "R6 unsigned less");
      drive(8'hEC, 5, 0, 64'hFFFF_FFFF_FFFF_FFFF, 32'h0000_0000, 1'b1, "R8 zero size compare eq");
      drive(8'hED, 5, 0, 64'hFFFF_FFFF_FFFF_FFFF, 32'h0000_0003, 1'b1, "R8 zero size compare lt");
      drive(8'hEC, 40, 30, 64'hFFFF_FFFF_FFFF_FFFF, 32'h0, 1'b1, "R9 R10 compare fault");
      idle();
      drive_bad(8'hF0);
      drive_bad(8'hEA);
      drive_bad(8'h00);

      for (int k = 0; k < 300; k++) begin
         logic [7:0] op;
         op = 8'hEC + 8'($urandom_range(0, 3));
         drive(op, $urandom_range(0, 63), $urandom_range(0, 36),
               {$urandom, $urandom}, $urandom, 1'($urandom), "R3 R4 R6 random");
         if ($urandom_range(0, 3) == 0) idle();
      end
      idle();
      repeat (3) @(negedge clk);
      tests++;
      if (sb.size() != 0) begin
         fails++;
         $display("FAIL R2: %0d results missing, expected 0", sb.size());
      end
      finish_run();
   end
endmodule